// File: doc/BRIEF.md
# ADC Acquisition and Conversion Sequencer

This block times one analog-to-digital converter channel. It runs an acquisition (sample) phase and decides when that phase ends. It then counts a fixed conversion window and stores the converter's output word in a result buffer. A 3-bit trigger select decides how acquisition ends. A software strobe can end it. A counted auto-start can end it after a programmed number of conversion clock ticks. One of three external event inputs can also end it, after a two-flop synchronizer, rising-edge detection and a fixed synchronization wait. A programmable divider derives the conversion clock tick from the fast input clock. The divider restarts at the entry of each timed phase, so every phase length is an exact multiple of the tick period.

Dropping `enable` while a sample, sync or conversion is in progress aborts the run. The result buffer keeps the last completed value, or the last value software wrote into it. The sequencer then enforces a two-tick recovery before any new acquisition can start. In auto-start mode, a completed conversion goes straight into a new acquisition for as long as `enable` stays high.

The states are OFF (disabled), IDLE (enabled, waiting for `samp_set`), SAMPLE (acquiring), SYNC (external-trigger synchronization wait), CONVERT (twelve-tick conversion) and RECOVER (post-abort wait). The transitions are:
- OFF→IDLE when `enable` is high.
- IDLE→OFF when `enable` is low.
- IDLE→SAMPLE on `samp_set`.
- SAMPLE→CONVERT on a software strobe or an auto-start count.
- SAMPLE→SYNC on a selected external edge.
- SYNC→CONVERT after two ticks.
- CONVERT→IDLE in the software and external modes.
- CONVERT→SAMPLE in auto-start mode.
- SAMPLE, SYNC or CONVERT→RECOVER on abort.
- RECOVER→OFF after two ticks.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The conversion tick occurs once every `div_sel`+1 input clock cycles. The tick counter restarts on entry to every state, so a phase of N ticks lasts exactly N*(`div_sel`+1) cycles.
- R2: Trigger select codes 000, 100, 101 and 110 are software modes. A `samp_set` pulse in IDLE enters SAMPLE on the next edge. A `samp_clr` pulse in SAMPLE enters CONVERT on the next edge. External inputs are ignored. After the conversion the sequencer returns to IDLE.
- R3: Code 111 is auto-start. CONVERT is entered max(`samp_cnt`,1) ticks after SAMPLE entry, so `samp_cnt`=1 gives 13 ticks from acquisition start to result. After each completion SAMPLE restarts at once while `enable` stays high.
- R4: Codes 001, 010 and 011 select `ext_trig[0]`, `ext_trig[1]` and `ext_trig[2]`. A rising edge on the selected input, driven before clock edge k, moves SAMPLE to SYNC at edge k+2. SYNC lasts 2 ticks before CONVERT. Edges on unselected inputs are ignored.
- R5: CONVERT lasts 12 ticks. At its final edge, `result` takes `conv_data` and `done` is high for exactly one cycle, in the same cycle as the new result.
- R6: `enable` low in SAMPLE, SYNC or CONVERT moves the sequencer to RECOVER at the next edge. The buffer is not written and no `done` is produced.
- R7: If `enable` is low in the cycle in which an auto-start count would end acquisition, the abort wins: the next state is RECOVER and CONVERT is never entered.
- R8: RECOVER lasts 2 ticks. `samp_set` is ignored during RECOVER. RECOVER then goes to OFF, and to IDLE one cycle later if `enable` is high.
- R9: A `buf_wr` pulse loads `buf_wdata` into `result` on the next edge, unless a conversion completes in the same cycle; the completion wins.
- R10: During and after reset the sequencer is in OFF, `result` is 0, and `done`, `sampling`, `converting` and `recovering` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Sequencer on; low aborts a run in progress |
| div_sel | input | DIV_W (6) | Tick divider setting; tick period is div_sel+1 cycles |
| trig_sel | input | 3 | Acquisition-end source select |
| samp_cnt | input | SAMP_W (5) | Auto-start acquisition length in ticks (0 acts as 1) |
| samp_set | input | 1 | Start-acquisition strobe |
| samp_clr | input | 1 | Software end-of-acquisition strobe |
| ext_trig | input | 3 | Asynchronous external trigger events |
| conv_data | input | DATA_W (10) | Converter output word |
| buf_wr | input | 1 | Direct write strobe for the result buffer |
| buf_wdata | input | DATA_W (10) | Data for a direct buffer write |
| result | output | DATA_W (10) | Result buffer |
| done | output | 1 | One-cycle completion pulse |
| sampling | output | 1 | High in SAMPLE |
| converting | output | 1 | High in CONVERT |
| recovering | output | 1 | High in RECOVER |

## Verification
Two functions can fall in the same cycle: the auto-start count expiring and an abort. The bench provokes this with an auto-start acquisition of two ticks at a divider setting of 1. It drops `enable` in exactly the last cycle of SAMPLE. One cycle later it requires `recovering` high, `converting` low and the buffer unchanged. It then requires that `samp_set` is ignored for the whole recovery window, and it checks the exact cycle at which RECOVER ends. A separate run aborts in the middle of CONVERT and confirms that no completion and no buffer update follow.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_SAMPLE,
        ST_SYNC,
        ST_CONVERT,
        ST_RECOVER
    } seq_state_t;

    typedef enum logic [1:0] {
        TM_SOFT,
        TM_AUTO,
        TM_EXT
    } trig_mode_t;

    localparam int EXT_INPUTS  = 3;
    localparam int SYNC_STAGES = 2;
    localparam int CONV_TICKS  = 12;
    localparam int SYNC_TICKS  = 2;
    localparam int RECOV_TICKS = 2;

    function automatic trig_mode_t decode_mode(input logic [2:0] sel);
        trig_mode_t m;
        unique case (sel)
            3'b001, 3'b010, 3'b011: m = TM_EXT;
            3'b111:                 m = TM_AUTO;
            default:                m = TM_SOFT;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/adc_tick_div.sv
module adc_tick_div #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             restart,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q >= div_sel);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R1
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (div_sel != '0)) |=> (!tick || (div_sel == '0)));

endmodule

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] rise
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_lane
        logic [STAGES:0] sh_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_q <= '0;
            end else begin
                sh_q <= {sh_q[STAGES-1:0], async_in[g]};
            end
        end

        assign rise[g] = sh_q[STAGES-1] & ~sh_q[STAGES];
    end

    // R4
    rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise & $past(rise)) == '0));

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int SAMP_W = 5,
    parameter int DATA_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic [2:0]            trig_sel,
    input  logic [SAMP_W-1:0]     samp_cnt,
    input  logic                  samp_set,
    input  logic                  samp_clr,
    input  logic [EXT_INPUTS-1:0] ext_rise,
    input  logic                  tick,
    input  logic [DATA_W-1:0]     conv_data,
    input  logic                  buf_wr,
    input  logic [DATA_W-1:0]     buf_wdata,
    output logic                  restart,
    output logic [DATA_W-1:0]     result,
    output logic                  done,
    output logic                  sampling,
    output logic                  converting,
    output logic                  recovering
);

    localparam int CNT_W = (SAMP_W > 4) ? SAMP_W : 4;

    seq_state_t        state_q, state_d;
    trig_mode_t        mode;
    logic [CNT_W-1:0]  tcnt_q;
    logic [CNT_W-1:0]  target;
    logic [CNT_W:0]    tcnt_inc;
    logic              last_tick;
    logic [3:0]        rise_pad;
    logic [1:0]        ext_idx;
    logic              ext_hit;
    logic              complete;
    logic [DATA_W-1:0] result_q;
    logic              done_q;

    assign mode     = decode_mode(trig_sel);
    assign rise_pad = {1'b0, ext_rise};
    assign ext_idx  = trig_sel[1:0] - 2'd1;
    assign ext_hit  = rise_pad[ext_idx];

    // Tick target for the phase in progress
    always_comb begin
        unique case (state_q)
            ST_SAMPLE:  target = (samp_cnt == '0) ? CNT_W'(1) : CNT_W'(samp_cnt);
            ST_SYNC:    target = CNT_W'(SYNC_TICKS);
            ST_CONVERT: target = CNT_W'(CONV_TICKS);
            ST_RECOVER: target = CNT_W'(RECOV_TICKS);
            default:    target = CNT_W'(1);
        endcase
    end

    assign tcnt_inc  = {1'b0, tcnt_q} + {{CNT_W{1'b0}}, 1'b1};
    assign last_tick = tick && (tcnt_inc == {1'b0, target});

    // Next-state logic; abort is checked before any trigger
    always_comb begin
        state_d  = state_q;
        complete = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (enable) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (!enable)       state_d = ST_OFF;
                else if (samp_set) state_d = ST_SAMPLE;
            end
            ST_SAMPLE: begin
                if (!enable) begin
                    state_d = ST_RECOVER;
                end else begin
                    unique case (mode)
                        TM_AUTO: if (last_tick) state_d = ST_CONVERT;
                        TM_EXT:  if (ext_hit)   state_d = ST_SYNC;
                        default: if (samp_clr)  state_d = ST_CONVERT;
                    endcase
                end
            end
            ST_SYNC: begin
                if (!enable)        state_d = ST_RECOVER;
                else if (last_tick) state_d = ST_CONVERT;
            end
            ST_CONVERT: begin
                if (!enable) begin
                    state_d = ST_RECOVER;
                end else if (last_tick) begin
                    complete = 1'b1;
                    state_d  = (mode == TM_AUTO) ? ST_SAMPLE : ST_IDLE;
                end
            end
            ST_RECOVER: begin
                if (last_tick) state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    assign restart = (state_d != state_q);

    // State and phase tick counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            tcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (restart)   tcnt_q <= '0;
            else if (tick) tcnt_q <= tcnt_q + 1'b1;
        end
    end

    // Registered outputs: result buffer and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= complete;
            if (complete)    result_q <= conv_data;
            else if (buf_wr) result_q <= buf_wdata;
        end
    end

    assign result     = result_q;
    assign done       = done_q;
    assign sampling   = (state_q == ST_SAMPLE);
    assign converting = (state_q == ST_CONVERT);
    assign recovering = (state_q == ST_RECOVER);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R6
    recover_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECOVER) |-> !done_q);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_q) |-> (done_q || $past(buf_wr)));

    // R7
    abort_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAMPLE && !enable) |=> (state_q == ST_RECOVER));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int DIV_W  = 6,
    parameter int SAMP_W = 5,
    parameter int DATA_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic [DIV_W-1:0]      div_sel,
    input  logic [2:0]            trig_sel,
    input  logic [SAMP_W-1:0]     samp_cnt,
    input  logic                  samp_set,
    input  logic                  samp_clr,
    input  logic [EXT_INPUTS-1:0] ext_trig,
    input  logic [DATA_W-1:0]     conv_data,
    input  logic                  buf_wr,
    input  logic [DATA_W-1:0]     buf_wdata,
    output logic [DATA_W-1:0]     result,
    output logic                  done,
    output logic                  sampling,
    output logic                  converting,
    output logic                  recovering
);

    logic                  tick;
    logic                  restart;
    logic [EXT_INPUTS-1:0] ext_rise;

    adc_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (div_sel),
        .restart (restart),
        .tick    (tick)
    );

    adc_trig_sync #(.WIDTH(EXT_INPUTS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_trig),
        .rise     (ext_rise)
    );

    adc_seq_fsm #(.SAMP_W(SAMP_W), .DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .trig_sel   (trig_sel),
        .samp_cnt   (samp_cnt),
        .samp_set   (samp_set),
        .samp_clr   (samp_clr),
        .ext_rise   (ext_rise),
        .tick       (tick),
        .conv_data  (conv_data),
        .buf_wr     (buf_wr),
        .buf_wdata  (buf_wdata),
        .restart    (restart),
        .result     (result),
        .done       (done),
        .sampling   (sampling),
        .converting (converting),
        .recovering (recovering)
    );

endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [5:0] div_sel = '0;
    logic [2:0] trig_sel = '0;
    logic [4:0] samp_cnt = '0;
    logic       samp_set = 1'b0;
    logic       samp_clr = 1'b0;
    logic [2:0] ext_trig = '0;
    logic [9:0] conv_data = '0;
    logic       buf_wr = 1'b0;
    logic [9:0] buf_wdata = '0;
    logic [9:0] result;
    logic       done, sampling, converting, recovering;

    int unsigned cyc = 0;
    int          total = 0;
    int          bad = 0;
    bit          finished = 0;

    typedef struct {
        int unsigned at;
        logic [9:0]  val;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    adc_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_sel(div_sel),
        .trig_sel(trig_sel), .samp_cnt(samp_cnt), .samp_set(samp_set),
        .samp_clr(samp_clr), .ext_trig(ext_trig), .conv_data(conv_data),
        .buf_wr(buf_wr), .buf_wdata(buf_wdata), .result(result), .done(done),
        .sampling(sampling), .converting(converting), .recovering(recovering)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    task automatic push(input int unsigned at, input logic [9:0] val, input string tag);
        exp_t e;
        e.at = at; e.val = val; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic pulse_set(output int unsigned t);
        t = cyc;
        samp_set = 1'b1;
        @(negedge clk);
        samp_set = 1'b0;
    endtask

    task automatic pulse_clr(output int unsigned t);
        t = cyc;
        samp_clr = 1'b1;
        @(negedge clk);
        samp_clr = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // Scoreboard monitor: every done pulse must match the next expected item
    always @(negedge clk) begin
        if (rst_n && done && !finished) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R5/R6 unexpected done: actual result=%0h expected no done (cycle %0d)",
                         result, cyc);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (cyc != e.at || result != e.val) begin
                    bad++;
                    $display("FAIL %s: actual cycle=%0d result=%0h expected cycle=%0d result=%0h",
                             e.tag, cyc, result, e.at, e.val);
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc == 100000 && !finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned t;
        int unsigned t0;
        repeat (4) @(negedge clk);
        chk(result == 0 && !done && !sampling && !converting && !recovering,
            "R10 reset state", {result, done, sampling, converting, recovering}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(result == 0 && !sampling && !recovering, "R10 after reset", result, 0);

        // Software trigger, divider 1
        div_sel = 6'd1; trig_sel = 3'b000; enable = 1'b1;
        repeat (2) @(negedge clk);
        pulse_set(t);
        chk(sampling == 1'b1, "R2 sample entered", sampling, 1);
        repeat (3) @(negedge clk);
        conv_data = 10'h155;
        pulse_clr(t);
        push(t + 1 + 12 * 2, 10'h155, "R2 R5 R1 software conversion");
        drain();
        chk(!sampling && !converting, "R2 back to idle", {sampling, converting}, 0);

        // Auto-start, samp_cnt 1, divider 3, with reacquisition
        div_sel = 6'd3; trig_sel = 3'b111; samp_cnt = 5'd1; conv_data = 10'h2AA;
        @(negedge clk);
        pulse_set(t);
        push(t + 1 + 13 * 4, 10'h2AA, "R3 R1 auto-start first");
        push(t + 1 + 26 * 4, 10'h0F0, "R3 auto reacquire");
        while (exp_q.size() == 2) @(negedge clk);
        conv_data = 10'h0F0;
        drain();
        chk(sampling == 1'b1, "R3 resampling after completion", sampling, 1);
        enable = 1'b0;
        repeat (11) @(negedge clk);
        chk(!recovering && !sampling, "R6 R8 stopped after abort", {recovering, sampling}, 0);

        // Auto-start with samp_cnt 0 treated as 1, divider 0
        div_sel = 6'd0; samp_cnt = 5'd0; conv_data = 10'h033; enable = 1'b1;
        @(negedge clk);
        pulse_set(t);
        push(t + 1 + 13, 10'h033, "R3 zero count acts as one");
        drain();
        enable = 1'b0;
        repeat (5) @(negedge clk);

        // Auto-start with samp_cnt 5, divider 1
        div_sel = 6'd1; samp_cnt = 5'd5; conv_data = 10'h1A5; enable = 1'b1;
        @(negedge clk);
        pulse_set(t);
        push(t + 1 + 17 * 2, 10'h1A5, "R3 R1 count of five");
        drain();
        enable = 1'b0;
        repeat (8) @(negedge clk);

        // External trigger on input 1, divider 2
        div_sel = 6'd2; trig_sel = 3'b010; enable = 1'b1;
        @(negedge clk);
        pulse_set(t);
        repeat (2) @(negedge clk);
        ext_trig = 3'b001;
        repeat (3) @(negedge clk);
        ext_trig = 3'b000;
        repeat (4) @(negedge clk);
        chk(sampling == 1'b1, "R4 unselected input ignored", sampling, 1);
        conv_data = 10'h2D2;
        t = cyc;
        ext_trig = 3'b010;
        push(t + 3 + 14 * 3, 10'h2D2, "R4 R1 external trigger");
        repeat (4) @(negedge clk);
        ext_trig = 3'b000;
        drain();
        chk(!sampling, "R4 idle after external conversion", sampling, 0);

        // Unused code 101 behaves as software mode
        div_sel = 6'd1; trig_sel = 3'b101;
        @(negedge clk);
        pulse_set(t);
        ext_trig = 3'b111;
        repeat (4) @(negedge clk);
        ext_trig = 3'b000;
        repeat (2) @(negedge clk);
        chk(sampling == 1'b1, "R2 code 101 ignores external inputs", sampling, 1);
        conv_data = 10'h066;
        pulse_clr(t);
        push(t + 1 + 24, 10'h066, "R2 code 101 software conversion");
        drain();

        // Direct buffer write
        @(negedge clk);
        buf_wdata = 10'h3C3; buf_wr = 1'b1;
        @(negedge clk);
        buf_wr = 1'b0;
        chk(result == 10'h3C3, "R9 buffer write", result, 10'h3C3);

        // Abort during conversion
        trig_sel = 3'b000;
        pulse_set(t);
        repeat (2) @(negedge clk);
        conv_data = 10'h111;
        pulse_clr(t);
        chk(converting == 1'b1, "R2 converting", converting, 1);
        repeat (5) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(recovering && !converting, "R6 abort to recover", {recovering, converting}, 2);
        repeat (30) @(negedge clk);
        chk(result == 10'h3C3, "R6 buffer keeps written value", result, 10'h3C3);

        // Abort in the same cycle as an auto-start
        trig_sel = 3'b111; samp_cnt = 5'd2; div_sel = 6'd1; enable = 1'b1;
        @(negedge clk);
        t0 = cyc;
        samp_set = 1'b1;
        @(negedge clk);
        samp_set = 1'b0;
        chk(sampling == 1'b1, "R7 sampling", sampling, 1);
        repeat (3) @(negedge clk);
        chk(cyc == t0 + 4 && sampling, "R7 last sample cycle", cyc, t0 + 4);
        enable = 1'b0;
        @(negedge clk);
        chk(recovering && !converting, "R7 abort beats auto-start", {recovering, converting}, 2);
        chk(result == 10'h3C3, "R7 buffer unchanged", result, 10'h3C3);
        enable = 1'b1; samp_set = 1'b1;
        @(negedge clk);
        samp_set = 1'b0;
        chk(!sampling && recovering, "R8 start ignored in recovery", sampling, 0);
        repeat (2) @(negedge clk);
        chk(recovering == 1'b1, "R8 still recovering", recovering, 1);
        @(negedge clk);
        chk(recovering == 1'b0, "R8 recovery length two ticks", recovering, 0);
        @(negedge clk);
        conv_data = 10'h0AB;
        pulse_set(t);
        chk(sampling == 1'b1, "R8 new acquisition after recovery", sampling, 1);
        push(t + 1 + 14 * 2, 10'h0AB, "R8 R3 restart after recovery");
        drain();
        enable = 1'b0;
        repeat (8) @(negedge clk);

        chk(exp_q.size() == 0, "R5 all expected completions seen", exp_q.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule